// File: doc/BRIEF.md
# Priority Round-Robin Transmit Channel Scheduler

This block decides which of several transmit channels may send its next packet onto one shared 128-bit packet stream. A channel can compete only while two things are true: the queue in front of it reports pending work, and the channel has been switched on. Every channel has a two-bit priority level. The most urgent level that has a competing channel always takes the stream. Channels that share that level take turns. Once a channel holds the stream it keeps it for the whole packet. The block passes beats through and never looks at what they contain.

Software-style control commands act on one channel at a time. Enable switches a channel on. Disable cuts it off at once, even in the middle of a packet. Pause lets a packet already in flight finish and then switches the channel off. Teardown does the same and then acknowledges completion with a one-cycle pulse.

Each channel source has its own valid/ready pair. Only the granted source ever sees ready. That ready equals the ready of the downstream sink, so back-pressure passes straight through with no buffering. `out_valid` follows the granted source's valid. A beat is transferred in a cycle where `out_valid` and `out_ready` are both high. While the sink holds ready low, the block keeps the same channel selected, so a source that holds its beat steady produces a steady output.

Top module: `tx_chan_sched`

## Requirements
- R1: A channel may receive a grant only when its `qpend` bit is high and it is in the enabled state. Channels that are switched off, pausing or tearing down never win.
- R2: Channel i has its level in `chan_prio[2i+1:2i]`. Level 3 is the most urgent and level 0 the least. An eligible channel never loses arbitration to a channel of a lower level.
- R3: Among eligible channels of one level, the search starts just after the last channel of that level that completed a packet and goes in ascending index order, wrapping around. After reset each level's search starts at channel 0.
- R4: Arbitration happens in a cycle with no grant held. The grant becomes visible on the next cycle. It stays on that channel until the beat with `out_last` set is accepted, and the cycle after that acceptance carries no grant.
- R5: Only the granted source sees `in_ready`, and its `in_ready` equals `out_ready`. `out_valid` equals that source's `in_valid`, and `out_data`, `out_last` and `out_chan` come from that source.
- R6: A disable command (`cmd_op`=1) switches the channel off on the next cycle. If the channel holds the grant, the grant is dropped on that same next cycle, even mid-packet.
- R7: A pause command (`cmd_op`=2) on the granted channel lets the packet finish and then switches the channel off. A pause on any other enabled channel switches it off at once.
- R8: A teardown command (`cmd_op`=3) on the granted channel waits until its last beat is accepted. On any other channel it completes at once. Either way the channel ends up switched off, and the matching `td_done` bit is high for exactly the one cycle after completion.
- R9: An enable command (`cmd_op`=0) switches a channel on, and it also cancels a pending pause. While a teardown is pending, an enable has no effect.
- R10: Reset switches every channel off and drops any grant. Level search pointers restart at the top index. `out_valid`, `in_ready` and `td_done` are all low.
- R11: If a command names the channel that would win the idle arbitration in the same cycle, that grant is withheld for the cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| qpend | input | NCH | Per-channel queue-pending indication |
| chan_prio | input | NCH*LVL_W | Per-channel priority level, 3 most urgent |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_chan | input | IW | Channel the command targets |
| cmd_op | input | 2 | 0 enable, 1 disable, 2 pause, 3 teardown |
| in_data | input | NCH*DW | Per-channel beat data, channel i at [i*DW +: DW] |
| in_valid | input | NCH | Per-channel beat valid |
| in_last | input | NCH | Per-channel end-of-packet marker |
| in_ready | output | NCH | Per-channel ready, only the granted channel |
| out_data | output | DW | Shared stream data |
| out_valid | output | 1 | Shared stream valid |
| out_last | output | 1 | Shared stream end-of-packet |
| out_chan | output | IW | Index of the channel currently granted |
| out_ready | input | 1 | Downstream ready |
| td_done | output | NCH | One-cycle teardown-complete pulse per channel |

## Verification
A wrong channel state, a stale level pointer or a grant that is never released all show up at the ports. Each one changes which channel is driven onto `out_chan` and `in_ready`. A wrong state makes a switched-off channel win, or an enabled one get skipped, on the next idle arbitration cycle. A bad pointer gives the wrong turn order on the next packet of that level. A grant that is not released, or is dropped too early, breaks the rule of one idle cycle after each last beat. A teardown that never completes shows up as a missing or misplaced `td_done` pulse. Because the reference model is compared against every output on every cycle, any of these is reported within one cycle of the first place the two diverge.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

  typedef enum logic [1:0] {
    OP_ENABLE   = 2'd0,
    OP_DISABLE  = 2'd1,
    OP_PAUSE    = 2'd2,
    OP_TEARDOWN = 2'd3
  } chan_op_e;

  typedef enum logic [1:0] {
    ST_OFF     = 2'd0,
    ST_ON      = 2'd1,
    ST_DRAIN_P = 2'd2,
    ST_DRAIN_T = 2'd3
  } chan_st_e;

endpackage

// File: rtl/tcs_chan_fsm.sv
module tcs_chan_fsm
  import tcs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_hit,
  input  logic [1:0] cmd_op,
  input  logic       granted,
  input  logic       eop_here,
  input  logic       qpend,
  output logic       elig,
  output logic       td_done
);

  chan_st_e st_q, st_d;
  logic     td_d;
  chan_op_e op;

  assign op = chan_op_e'(cmd_op);

  always_comb begin
    st_d = st_q;
    td_d = 1'b0;
    if (cmd_hit) begin
      unique case (op)
        OP_ENABLE:  if (st_q != ST_DRAIN_T) st_d = ST_ON;
        OP_DISABLE: st_d = ST_OFF;
        OP_PAUSE:   if (st_q == ST_ON || st_q == ST_DRAIN_P)
                      st_d = granted ? ST_DRAIN_P : ST_OFF;
        OP_TEARDOWN: if (st_q != ST_DRAIN_T) begin
                      if (granted) st_d = ST_DRAIN_T;
                      else begin
                        st_d = ST_OFF;
                        td_d = 1'b1;
                      end
                    end
        default: st_d = st_q;
      endcase
    end
    if (eop_here) begin
      if (st_d == ST_DRAIN_P) st_d = ST_OFF;
      else if (st_d == ST_DRAIN_T) begin
        st_d = ST_OFF;
        td_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_OFF;
      td_done <= 1'b0;
    end else begin
      st_q    <= st_d;
      td_done <= td_d;
    end
  end

  assign elig = qpend && (st_q == ST_ON);

  // R6
  dis_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_hit && op == OP_DISABLE) |=> (st_q == ST_OFF));

  // R8
  td_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    td_done |-> (st_q == ST_OFF));

  // R9
  tear_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DRAIN_T && !eop_here && !(cmd_hit && op == OP_DISABLE))
      |=> (st_q == ST_DRAIN_T));

endmodule

// File: rtl/tcs_prio_arb.sv
module tcs_prio_arb #(
  parameter int unsigned NCH   = 8,
  parameter int unsigned LVL_W = 2,
  localparam int unsigned IW    = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int unsigned N_LVL = 1 << LVL_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NCH-1:0]         elig,
  input  logic [NCH*LVL_W-1:0]   prio,
  input  logic                   upd,
  input  logic [IW-1:0]          upd_idx,
  input  logic [LVL_W-1:0]       upd_lvl,
  output logic                   win_valid,
  output logic [IW-1:0]          win_idx,
  output logic [LVL_W-1:0]       win_lvl
);

  logic [IW-1:0]    rr_q     [N_LVL];
  logic [N_LVL-1:0] lvl_any;
  logic [IW-1:0]    lvl_pick [N_LVL];

  for (genvar gl = 0; gl < N_LVL; gl++) begin : g_lvl
    logic [NCH-1:0] mask;
    logic           any;
    logic [IW-1:0]  pick;

    always_comb begin
      for (int i = 0; i < NCH; i++)
        mask[i] = elig[i] && (prio[i*LVL_W +: LVL_W] == LVL_W'(gl));
    end

    always_comb begin
      any  = 1'b0;
      pick = '0;
      for (int k = NCH; k >= 1; k--) begin
        if (mask[(int'(rr_q[gl]) + k) % NCH]) begin
          any  = 1'b1;
          pick = IW'((int'(rr_q[gl]) + k) % NCH);
        end
      end
    end

    assign lvl_any[gl]  = any;
    assign lvl_pick[gl] = pick;
  end

  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_lvl   = '0;
    for (int l = 0; l < N_LVL; l++) begin
      if (lvl_any[l]) begin
        win_valid = 1'b1;
        win_idx   = lvl_pick[l];
        win_lvl   = LVL_W'(l);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < N_LVL; l++) rr_q[l] <= IW'(NCH - 1);
    end else if (upd) begin
      rr_q[upd_lvl] <= upd_idx;
    end
  end

  logic hi_seen;
  always_comb begin
    hi_seen = 1'b0;
    for (int i = 0; i < NCH; i++)
      if (elig[i] && prio[i*LVL_W +: LVL_W] > win_lvl) hi_seen = 1'b1;
  end

  // R1
  win_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> elig[win_idx]);

  // R2
  win_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> !hi_seen);

  // R1
  idle_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (elig == '0) |-> !win_valid);

endmodule

// File: rtl/tcs_stream_mux.sv
module tcs_stream_mux #(
  parameter int unsigned NCH = 8,
  parameter int unsigned DW  = 128,
  localparam int unsigned IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              busy,
  input  logic [IW-1:0]     gnt,
  input  logic [NCH*DW-1:0] in_data,
  input  logic [NCH-1:0]    in_valid,
  input  logic [NCH-1:0]    in_last,
  output logic [NCH-1:0]    in_ready,
  output logic [DW-1:0]     out_data,
  output logic              out_valid,
  output logic              out_last,
  input  logic              out_ready
);

  always_comb begin
    out_data  = in_data[gnt*DW +: DW];
    out_valid = busy && in_valid[gnt];
    out_last  = in_last[gnt];
    in_ready  = '0;
    if (busy) in_ready[gnt] = out_ready;
  end

endmodule

// File: rtl/tx_chan_sched.sv
module tx_chan_sched
  import tcs_pkg::*;
#(
  parameter int unsigned NCH   = 8,
  parameter int unsigned DW    = 128,
  parameter int unsigned LVL_W = 2,
  localparam int unsigned IW   = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCH-1:0]       qpend,
  input  logic [NCH*LVL_W-1:0] chan_prio,
  input  logic                 cmd_valid,
  input  logic [IW-1:0]        cmd_chan,
  input  logic [1:0]           cmd_op,
  input  logic [NCH*DW-1:0]    in_data,
  input  logic [NCH-1:0]       in_valid,
  input  logic [NCH-1:0]       in_last,
  output logic [NCH-1:0]       in_ready,
  output logic [DW-1:0]        out_data,
  output logic                 out_valid,
  output logic                 out_last,
  output logic [IW-1:0]        out_chan,
  input  logic                 out_ready,
  output logic [NCH-1:0]       td_done
);

  logic             busy_q;
  logic [IW-1:0]    gnt_q;
  logic [LVL_W-1:0] glvl_q;
  logic [NCH-1:0]   elig;
  logic             win_valid;
  logic [IW-1:0]    win_idx;
  logic [LVL_W-1:0] win_lvl;
  logic             eop, kill, grant_ok;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tcs_chan_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_hit  (cmd_valid && cmd_chan == IW'(c)),
      .cmd_op   (cmd_op),
      .granted  (busy_q && gnt_q == IW'(c)),
      .eop_here (eop && gnt_q == IW'(c)),
      .qpend    (qpend[c]),
      .elig     (elig[c]),
      .td_done  (td_done[c])
    );
  end

  tcs_prio_arb #(.NCH(NCH), .LVL_W(LVL_W)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .elig      (elig),
    .prio      (chan_prio),
    .upd       (eop),
    .upd_idx   (gnt_q),
    .upd_lvl   (glvl_q),
    .win_valid (win_valid),
    .win_idx   (win_idx),
    .win_lvl   (win_lvl)
  );

  tcs_stream_mux #(.NCH(NCH), .DW(DW)) u_mux (
    .busy      (busy_q),
    .gnt       (gnt_q),
    .in_data   (in_data),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .in_ready  (in_ready),
    .out_data  (out_data),
    .out_valid (out_valid),
    .out_last  (out_last),
    .out_ready (out_ready)
  );

  assign eop      = out_valid && out_ready && out_last;
  assign kill     = busy_q && cmd_valid && cmd_chan == gnt_q
                    && chan_op_e'(cmd_op) == OP_DISABLE;
  assign grant_ok = !busy_q && win_valid && !(cmd_valid && cmd_chan == win_idx);
  assign out_chan = gnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      gnt_q  <= '0;
      glvl_q <= '0;
    end else if (busy_q) begin
      if (eop || kill) busy_q <= 1'b0;
    end else if (grant_ok) begin
      busy_q <= 1'b1;
      gnt_q  <= win_idx;
      glvl_q <= win_lvl;
    end
  end

  // R4
  hold_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !eop && !kill) |=> (busy_q && $stable(gnt_q)));

  // R4
  gap_after_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eop |=> !busy_q);

  // R5
  rdy_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(in_ready));

  // R5
  rdy_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|in_ready) |-> (busy_q && out_ready));

  // R6
  kill_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> !busy_q);

  // R11
  race_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && cmd_valid && win_valid && cmd_chan == win_idx) |=> !busy_q);

endmodule

// File: tb/tx_chan_sched_bench.sv
module tx_chan_sched_bench;
  localparam int CLK_NS = 10;
  localparam int NCH = 8;
  localparam int DW = 128;
  localparam int LVL_W = 2;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] qpend = '0;
  logic [NCH*LVL_W-1:0] chan_prio = '0;
  logic cmd_valid = 1'b0;
  logic [IW-1:0] cmd_chan = '0;
  logic [1:0] cmd_op = '0;
  logic [NCH*DW-1:0] in_data = '0;
  logic [NCH-1:0] in_valid = '0;
  logic [NCH-1:0] in_last = '0;
  logic [NCH-1:0] in_ready;
  logic [DW-1:0] out_data;
  logic out_valid, out_last;
  logic [IW-1:0] out_chan;
  logic out_ready = 1'b0;
  logic [NCH-1:0] td_done;

  tx_chan_sched #(.NCH(NCH), .DW(DW), .LVL_W(LVL_W)) u_tx_chan_sched (
    .clk(clk), .rst_n(rst_n), .qpend(qpend), .chan_prio(chan_prio),
    .cmd_valid(cmd_valid), .cmd_chan(cmd_chan), .cmd_op(cmd_op),
    .in_data(in_data), .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid), .out_last(out_last),
    .out_chan(out_chan), .out_ready(out_ready), .td_done(td_done));

  always #(CLK_NS/2) clk = ~clk;

  // reference model: 0 off, 1 on, 2 pause pending, 3 teardown pending
  int mst[NCH];
  bit mtd[NCH];
  bit mbusy;
  int mg, mlvl;
  int mrr[4];
  int beat[NCH];
  int prio_i[NCH];
  logic [NCH-1:0] g_qpend = '0;
  bit g_ready = 1, g_stall = 0, g_cmdv = 0;
  int g_cmdc = 0, g_cmdop = 0;
  int vectors = 0, errors = 0;
  bit done = 0;
  string req = "R10";

  function automatic int plen(int c);
    return c % 3 + 1;
  endfunction

  function automatic logic [DW-1:0] beat_word(int c, int b);
    return DW'({8'(c), 8'(b), 8'hA5});
  endfunction

  function automatic int pick_win();
    for (int l = 3; l >= 0; l--)
      for (int k = 1; k <= NCH; k++) begin
        int j;
        j = (mrr[l] + k) % NCH;
        if (g_qpend[j] && mst[j] == 1 && prio_i[j] == l) return j;
      end
    return -1;
  endfunction

  task automatic tick();
    bit ev, el, fire, eop, ok;
    int w;
    int nst[NCH];
    bit ntd[NCH];
    logic [NCH-1:0] erdy, etd;
    @(negedge clk);
    qpend = g_qpend; out_ready = g_ready; cmd_valid = g_cmdv;
    cmd_chan = IW'(g_cmdc); cmd_op = 2'(g_cmdop);
    for (int c = 0; c < NCH; c++) begin
      in_valid[c] = !g_stall;
      in_last[c] = (beat[c] == plen(c) - 1);
      in_data[c*DW +: DW] = beat_word(c, beat[c]);
    end
    #1;
    ev = mbusy && !g_stall;
    el = mbusy && (beat[mg] == plen(mg) - 1);
    erdy = '0;
    if (mbusy && g_ready) erdy[mg] = 1'b1;
    for (int c = 0; c < NCH; c++) etd[c] = mtd[c];
    ok = (out_valid === ev) && (in_ready === erdy) && (td_done === etd);
    if (ev) ok = ok && (out_chan === IW'(mg)) && (out_last === el)
                 && (out_data === beat_word(mg, beat[mg]));
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s t=%0t: valid=%b chan=%0d last=%b rdy=%b td=%b | exp valid=%b chan=%0d last=%b rdy=%b td=%b",
               req, $time, out_valid, out_chan, out_last, in_ready, td_done,
               ev, mg, el, erdy, etd);
    end
    // model next state
    fire = ev && g_ready;
    eop = fire && el;
    w = mbusy ? -1 : pick_win();
    for (int c = 0; c < NCH; c++) begin nst[c] = mst[c]; ntd[c] = 0; end
    if (g_cmdv) begin
      int c;
      bit gr;
      c = g_cmdc;
      gr = mbusy && mg == c;
      case (g_cmdop)
        0: if (nst[c] != 3) nst[c] = 1;
        1: nst[c] = 0;
        2: if (nst[c] == 1 || nst[c] == 2) nst[c] = gr ? 2 : 0;
        default: if (nst[c] != 3) begin
          if (gr) nst[c] = 3;
          else begin nst[c] = 0; ntd[c] = 1; end
        end
      endcase
    end
    if (eop) begin
      if (nst[mg] == 2) nst[mg] = 0;
      else if (nst[mg] == 3) begin nst[mg] = 0; ntd[mg] = 1; end
    end
    if (fire) beat[mg] = el ? 0 : beat[mg] + 1;
    if (mbusy) begin
      if (eop) mrr[mlvl] = mg;
      if (eop || (g_cmdv && g_cmdop == 1 && g_cmdc == mg)) mbusy = 0;
    end else if (w >= 0 && !(g_cmdv && g_cmdc == w)) begin
      mbusy = 1; mg = w; mlvl = prio_i[w];
    end
    for (int c = 0; c < NCH; c++) begin mst[c] = nst[c]; mtd[c] = ntd[c]; end
    g_cmdv = 0;
  endtask

  task automatic send(int c, int op);
    g_cmdv = 1; g_cmdc = c; g_cmdop = op;
    tick();
  endtask

  task automatic cmd_on_granted(int op);
    for (int t = 0; t < 60; t++) begin
      if (mbusy && beat[mg] < plen(mg) - 1) begin
        send(mg, op);
        return;
      end
      tick();
    end
  endtask

  initial begin
    prio_i = '{0, 1, 1, 2, 3, 3, 0, 2};
    for (int c = 0; c < NCH; c++) begin
      chan_prio[c*LVL_W +: LVL_W] = LVL_W'(prio_i[c]);
      mst[c] = 0; mtd[c] = 0; beat[c] = 0;
    end
    for (int l = 0; l < 4; l++) mrr[l] = NCH - 1;
    mbusy = 0; mg = 0; mlvl = 0;
    // R10: outputs quiet while reset is held
    repeat (3) begin
      @(negedge clk); #1;
      vectors++;
      if (out_valid !== 1'b0 || in_ready !== '0 || td_done !== '0) begin
        errors++;
        $display("FAIL R10 reset: valid=%b rdy=%b td=%b exp 0 0 0", out_valid, in_ready, td_done);
      end
    end
    rst_n = 1'b1;
    // R1: pending work but every channel off -> no grant
    req = "R1"; g_qpend = '1; repeat (6) tick();
    // R9: enable all channels
    req = "R9"; for (int c = 0; c < NCH; c++) send(c, 0);
    // R2: level 3 channels 4 and 5 starve all others
    req = "R2"; repeat (40) tick();
    // R3: level 2 channels 3 and 7 take turns
    req = "R3"; g_qpend = 8'hCF; repeat (30) tick();
    // R5: sink back-pressure and source stalls
    req = "R5";
    for (int i = 0; i < 60; i++) begin
      g_ready = (i % 3 != 0); g_stall = (i % 5 == 2); tick();
    end
    g_ready = 1; g_stall = 0;
    // R1: queue pending dropped
    req = "R1"; g_qpend = '0; repeat (8) tick();
    // R7: pause in flight and pause on an idle channel
    req = "R7"; g_qpend = '1; cmd_on_granted(2); repeat (10) tick();
    send(1, 2); repeat (10) tick();
    // R8: teardown in flight, on an idle channel, on an off channel
    req = "R8"; cmd_on_granted(3); repeat (10) tick();
    send(6, 3); repeat (4) tick(); send(6, 3); repeat (4) tick();
    // R9: re-enable, then enable during a pending teardown is ignored
    req = "R9"; for (int c = 0; c < NCH; c++) send(c, 0);
    cmd_on_granted(3); send(g_cmdc, 0); repeat (10) tick();
    for (int c = 0; c < NCH; c++) send(c, 0);
    // R6: disable cuts a packet in flight
    req = "R6"; cmd_on_granted(1); repeat (10) tick();
    send(g_cmdc, 0);
    // R11: command on the idle arbitration winner withholds the grant
    req = "R11";
    for (int t = 0; t < 40; t++) begin
      if (!mbusy && pick_win() >= 0) send(pick_win(), 0);
      else tick();
    end
    // R4: long mixed traffic with random commands
    req = "R4";
    repeat (3000) begin
      g_qpend = NCH'($urandom);
      g_ready = ($urandom % 4) != 0;
      g_stall = ($urandom % 6) == 0;
      if ($urandom % 5 == 0) begin
        g_cmdv = 1; g_cmdc = int'($urandom % NCH);
        g_cmdop = ($urandom % 2 == 0) ? 0 : int'($urandom % 4);
      end
      tick();
    end
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: run did not end, exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule